// File: doc/BRIEF.md
# Two-Tier Interrupt Mask Arbiter

This block is the interrupt front end of a 16-bit word minicomputer. It keeps a 19-bit standard request/status register with a 16-bit enable mask, and a 16-bit extended request bitmap with its own 16-bit mask. Devices raise and drop request bits through single-cycle set and clear vectors. Software reloads the masks through an output-to-device write port that carries a device code and a function code. Illegal combinations are flagged as a bad function and change nothing.

At every instruction boundary the processor asks the arbiter for a decision. A standard interrupt is considered first. An extended interrupt is considered only when no standard one is taken. Both tiers are gated by a shared pending qualifier: the "interrupts on" bit and the "not deferred" bit must both be set. When an interrupt is taken, the arbiter does four things:

- It supplies an indirect jump-and-store instruction word through the interrupt vector, for the processor to execute in place of the next fetch.
- It pulses an acknowledge flag.
- It saves the extended-addressing mode into a previous-mode flag and forces the mode on when that option is built in.
- It clears "interrupts on", so no further interrupt is accepted until that bit is set again.

Top module: `irq_mask_arbiter`

## Requirements
- R1: After reset, all request bits, both masks and both mode flags are 0, and `int_ack`, `inj_word` and `wr_bad` read 0.
- R2: Each standard and extended request bit is set by its `*_set` bit and cleared by its `*_clr` bit in the same position. When both hit one bit in the same cycle, the bit ends up set.
- R3: Standard bit positions are: 16 start button (non-maskable), 17 not-deferred, 18 interrupts-on. Bits 0..15 are maskable device requests, enabled one for one by the standard mask. A standard interrupt is taken at a boundary only if bits 17 and 18 are both set and at least one of these is also set: bit 16, or a maskable bit whose mask bit is 1.
- R4: A standard interrupt's injected word is octal 120000 OR `STD_VEC` (octal 120063 with defaults).
- R5: An extended interrupt is taken only when no standard one is, bits 17 and 18 are both set, and the AND of extended requests and extended mask is non-zero. The lowest-numbered such line n wins, and its injected word is octal 120000 OR (`EXT_BASE` + n). With defaults this is octal 120100 + n.
- R6: On any taken interrupt, the previous-mode flag receives the old extended-addressing flag. The extended-addressing flag is forced to 1 when `EXT_ADDR_OPT` is 1 and left unchanged otherwise. Bit 18 is cleared, so no interrupt is taken again until `std_set[18]` is pulsed.
- R7: A write with device code octal 20 and function 0 loads the standard mask from `wr_data`. Function 1 loads the extended mask, but only when `EXT_LINES` is 16.
- R8: `wr_bad` is high, in the same cycle as `wr_valid`, for these writes:
  - any write to device octal 24;
  - device octal 20 with function 2 or 3;
  - device octal 20 with function 1 when `EXT_LINES` is not 16.

  Such writes leave both masks unchanged. Device octal 20 with a function of 4 or more is ignored without `wr_bad`.
- R9: `int_ack` is a one-cycle pulse in the cycle after a boundary cycle whose decision took an interrupt. `inj_word` updates in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_set | input | 19 | Per-bit set pulses for the standard register |
| std_clr | input | 19 | Per-bit clear pulses for the standard register |
| ext_set | input | 16 | Per-bit set pulses for the extended request bitmap |
| ext_clr | input | 16 | Per-bit clear pulses for the extended request bitmap |
| insn_boundary | input | 1 | High for one cycle at each instruction boundary |
| wr_valid | input | 1 | Output-to-device write strobe |
| wr_dev | input | 6 | Device code of the write |
| wr_fn | input | 4 | Function code of the write |
| wr_data | input | 16 | Data word of the write |
| wr_bad | output | 1 | Write rejected as a bad function (combinational) |
| int_ack | output | 1 | Interrupt taken at the previous boundary |
| inj_word | output | 16 | Injected indirect jump-and-store instruction word |
| ext_mode | output | 1 | Extended-addressing mode flag |
| prev_ext_mode | output | 1 | Mode flag saved at the last taken interrupt |

## Verification
The arbitration is driven with request and mask patterns that separate the cases one at a time:

- A masked request versus an enabled one.
- A qualifier that is half set versus fully set.
- The non-maskable start bit with an all-zero mask.
- An extended line whose mask bit is off versus on.
- Several extended lines at once, so that only the lowest-number rule picks the right vector.
- Standard and extended requests together, so that only the tier order yields the standard word.

Directed sequences cover the rest:

- Set and clear of one bit in the same cycle.
- Re-arming through bit 18 after a take.
- The previous-mode chain across two takes.
- Rejected writes, whose lack of effect shows up as a missing interrupt at the next boundary.
- A second build without extended lines or the addressing option.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int STD_W  = 19;
    localparam int EXT_W  = 16;
    localparam int WORD_W = 16;
    localparam int DEV_W  = 6;
    localparam int FN_W   = 4;

    localparam int BIT_START = 16;   // non-maskable start request
    localparam int BIT_NODEF = 17;   // not deferred
    localparam int BIT_ON    = 18;   // interrupts on

    localparam logic [WORD_W-1:0] JST_IND  = 16'o120000;
    localparam logic [DEV_W-1:0]  DEV_MASK = 6'o20;
    localparam logic [DEV_W-1:0]  DEV_RSVD = 6'o24;

    localparam logic [STD_W-1:0] PEND_QUAL = STD_W'(3) << BIT_NODEF;

    typedef struct packed {
        logic [STD_W-1:0]  std_req;
        logic [EXT_W-1:0]  std_enb;
        logic [EXT_W-1:0]  ext_req;
        logic [EXT_W-1:0]  ext_enb;
        logic              ext_mode;
        logic              prev_ext;
        logic              ack;
        logic [WORD_W-1:0] inj_word;
    } arb_state_t;
endpackage

// File: rtl/irq_std_arb.sv
module irq_std_arb
    import irq_arb_pkg::*;
(
    input  logic [STD_W-1:0] req,
    input  logic [EXT_W-1:0] enb,
    output logic             take,
    output logic             pend_full
);
    logic [STD_W-1:0] qual;
    logic [STD_W-1:0] masked;

    always_comb begin
        // qualifier bits, non-maskable start bit, then the maskable field
        qual      = {2'b11, 1'b1, enb};
        masked    = req & qual;
        take      = masked > PEND_QUAL;
        pend_full = req[BIT_ON] & req[BIT_NODEF];
    end
endmodule

// File: rtl/irq_ext_pick.sv
module irq_ext_pick #(
    parameter int W     = 16,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan downward so the lowest active line is written last
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_mask_port.sv
module irq_mask_port
    import irq_arb_pkg::*;
#(
    parameter int EXT_LINES = 16
) (
    input  logic             valid,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    output logic             ld_std,
    output logic             ld_ext,
    output logic             bad
);
    localparam bit EXT_OK = (EXT_LINES == 16);

    logic hit_mask;
    logic hit_rsvd;

    always_comb begin
        hit_mask = valid && (dev == DEV_MASK);
        hit_rsvd = valid && (dev == DEV_RSVD);
        ld_std   = hit_mask && (fn == FN_W'(0));
        ld_ext   = hit_mask && (fn == FN_W'(1)) && EXT_OK;
        bad      = hit_rsvd ||
                   (hit_mask && (((fn == FN_W'(1)) && !EXT_OK) ||
                                 (fn == FN_W'(2)) || (fn == FN_W'(3))));
    end
endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
    import irq_arb_pkg::*;
#(
    parameter logic [WORD_W-1:0] STD_VEC      = 16'o63,
    parameter logic [WORD_W-1:0] EXT_BASE     = 16'o100,
    parameter int                EXT_LINES    = 16,
    parameter bit                EXT_ADDR_OPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STD_W-1:0]  std_set,
    input  logic [STD_W-1:0]  std_clr,
    input  logic [EXT_W-1:0]  ext_set,
    input  logic [EXT_W-1:0]  ext_clr,
    input  logic              insn_boundary,
    input  logic              wr_valid,
    input  logic [DEV_W-1:0]  wr_dev,
    input  logic [FN_W-1:0]   wr_fn,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_bad,
    output logic              int_ack,
    output logic [WORD_W-1:0] inj_word,
    output logic              ext_mode,
    output logic              prev_ext_mode
);
    localparam int IDX_W = $clog2(EXT_W);

    arb_state_t s_d, s_q;

    logic             std_take;
    logic             pend_full;
    logic             ext_any;
    logic [IDX_W-1:0] ext_idx;
    logic             ext_take;
    logic             ld_std;
    logic             ld_ext;

    irq_std_arb u_std (
        .req       (s_q.std_req),
        .enb       (s_q.std_enb),
        .take      (std_take),
        .pend_full (pend_full)
    );

    irq_ext_pick #(.W(EXT_W), .IDX_W(IDX_W)) u_ext (
        .req (s_q.ext_req & s_q.ext_enb),
        .any (ext_any),
        .idx (ext_idx)
    );

    irq_mask_port #(.EXT_LINES(EXT_LINES)) u_port (
        .valid  (wr_valid),
        .dev    (wr_dev),
        .fn     (wr_fn),
        .ld_std (ld_std),
        .ld_ext (ld_ext),
        .bad    (wr_bad)
    );

    always_comb begin
        ext_take = !std_take && pend_full && ext_any;

        s_d         = s_q;
        s_d.ack     = 1'b0;
        // set wins over clear on the same bit
        s_d.std_req = (s_q.std_req & ~std_clr) | std_set;
        s_d.ext_req = (s_q.ext_req & ~ext_clr) | ext_set;
        if (ld_std) s_d.std_enb = wr_data;
        if (ld_ext) s_d.ext_enb = wr_data;

        if (insn_boundary && (std_take || ext_take)) begin
            s_d.ack      = 1'b1;
            s_d.inj_word = std_take ? (JST_IND | STD_VEC)
                                    : (JST_IND | (EXT_BASE + WORD_W'(ext_idx)));
            s_d.prev_ext = s_q.ext_mode;
            if (EXT_ADDR_OPT) s_d.ext_mode = 1'b1;
            s_d.std_req[BIT_ON] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_ack       = s_q.ack;
    assign inj_word      = s_q.inj_word;
    assign ext_mode      = s_q.ext_mode;
    assign prev_ext_mode = s_q.prev_ext;
endmodule

// File: rtl/irq_mask_arbiter_chk.sv
module irq_mask_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              insn_boundary,
    input logic              wr_valid,
    input logic [DEV_W-1:0]  wr_dev,
    input logic              wr_bad,
    input logic              int_ack,
    input logic [WORD_W-1:0] inj_word,
    input logic              ext_mode,
    input logic              prev_ext_mode
);
    p_ack_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> $past(insn_boundary));

    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_ack);

    p_prev_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> (prev_ext_mode == $past(ext_mode)));

    p_word_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ((inj_word & 16'o170000) == JST_IND));

    p_bad_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_dev == DEV_RSVD)) |-> wr_bad);

    p_bad_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |-> wr_valid);
endmodule

bind irq_mask_arbiter irq_mask_arbiter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .wr_valid      (wr_valid),
    .wr_dev        (wr_dev),
    .wr_bad        (wr_bad),
    .int_ack       (int_ack),
    .inj_word      (inj_word),
    .ext_mode      (ext_mode),
    .prev_ext_mode (prev_ext_mode)
);

// File: tb/sim_irq_mask_arbiter.sv
module sim_irq_mask_arbiter;
    import irq_arb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [STD_W-1:0]  std_set = '0, std_clr = '0;
    logic [EXT_W-1:0]  ext_set = '0, ext_clr = '0;
    logic              insn_boundary = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DEV_W-1:0]  wr_dev = '0;
    logic [FN_W-1:0]   wr_fn = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              wr_bad, int_ack, ext_mode, prev_ext_mode;
    logic [WORD_W-1:0] inj_word;
    logic              b_bad, b_ack, b_mode, b_prev;
    logic [WORD_W-1:0] b_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_mask_arbiter u0 (
        .clk, .rst_n, .std_set, .std_clr, .ext_set, .ext_clr, .insn_boundary,
        .wr_valid, .wr_dev, .wr_fn, .wr_data, .wr_bad, .int_ack, .inj_word,
        .ext_mode, .prev_ext_mode
    );

    irq_mask_arbiter #(.EXT_LINES(0), .EXT_ADDR_OPT(1'b0)) u1 (
        .clk, .rst_n, .std_set, .std_clr, .ext_set, .ext_clr, .insn_boundary,
        .wr_valid, .wr_dev, .wr_fn, .wr_data, .wr_bad(b_bad), .int_ack(b_ack),
        .inj_word(b_word), .ext_mode(b_mode), .prev_ext_mode(b_prev)
    );

    localparam logic [STD_W-1:0] PND = 19'h60000;

    typedef struct packed {
        logic [STD_W-1:0]  sreq;
        logic [EXT_W-1:0]  senb;
        logic [EXT_W-1:0]  ereq;
        logic [EXT_W-1:0]  emsk;
        logic              ack;
        logic [WORD_W-1:0] word;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{PND | 19'h1,     16'h0001, 16'h0000, 16'h0000, 1'b1, 16'o120063}, // R3 enabled request
        '{PND | 19'h1,     16'h0000, 16'h0000, 16'h0000, 1'b0, 16'o0},      // R3 masked
        '{19'h40001,       16'h0001, 16'h0000, 16'h0000, 1'b0, 16'o0},      // R3 half qualifier
        '{PND | 19'h10000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'o120063}, // R3 non-maskable
        '{PND,             16'h0000, 16'h0020, 16'h0020, 1'b1, 16'o120105}, // R5 line 5
        '{PND,             16'h0000, 16'h0208, 16'h0208, 1'b1, 16'o120103}, // R5 lowest wins
        '{PND,             16'h0000, 16'h8000, 16'h8000, 1'b1, 16'o120117}, // R5 line 15
        '{PND | 19'h4,     16'h0004, 16'h0002, 16'h0002, 1'b1, 16'o120063}, // R5 standard first
        '{19'h20000,       16'h0000, 16'h0010, 16'h0010, 1'b0, 16'o0},      // R5 no qualifier
        '{PND,             16'h0000, 16'h0010, 16'h0020, 1'b0, 16'o0},      // R5 masked line
        '{PND | 19'h000F0, 16'h000F, 16'h0000, 16'h0000, 1'b0, 16'o0}       // R3 disjoint mask
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        std_clr = '1; ext_clr = '1;
        @(negedge clk);
        std_clr = '0; ext_clr = '0;
    endtask

    task automatic wr(input logic [DEV_W-1:0] d, input logic [FN_W-1:0] f, input logic [WORD_W-1:0] x);
        @(negedge clk);
        wr_valid = 1'b1; wr_dev = d; wr_fn = f; wr_data = x;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_std(input logic [STD_W-1:0] v);
        @(negedge clk);
        std_set = v;
        @(negedge clk);
        std_set = '0;
    endtask

    task automatic boundary();
        @(negedge clk);
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(int_ack == 0 && inj_word == 0, "R1 ack/word", int_ack, 0);
        check(ext_mode == 0 && prev_ext_mode == 0, "R1 mode flags", ext_mode, 0);
        check(wr_bad == 0, "R1 bad flag", wr_bad, 0);
        boundary();
        check(int_ack == 0, "R1 no request after reset", int_ack, 0);

        // table of arbitration patterns
        for (int i = 0; i < NV; i++) begin
            clear_all();
            @(negedge clk);
            std_set = VEC[i].sreq; ext_set = VEC[i].ereq;
            wr_valid = 1'b1; wr_dev = 6'o20; wr_fn = 4'd0; wr_data = VEC[i].senb;
            @(negedge clk);
            std_set = '0; ext_set = '0;
            wr_fn = 4'd1; wr_data = VEC[i].emsk;
            @(negedge clk);
            wr_valid = 1'b0;
            insn_boundary = 1'b1;
            @(negedge clk);
            insn_boundary = 1'b0;
            check(int_ack == VEC[i].ack, $sformatf("R3/R5 vec %0d ack", i), int_ack, VEC[i].ack);
            if (VEC[i].ack)
                check(inj_word == VEC[i].word, $sformatf("R4/R5 vec %0d word", i), inj_word, VEC[i].word);
            @(negedge clk);
            check(int_ack == 0, $sformatf("R9 vec %0d pulse", i), int_ack, 0);
        end

        // R6 mode chain and re-arm, from a clean reset
        do_reset();
        clear_all();
        wr(6'o20, 4'd0, 16'h0001);
        pulse_std(PND | 19'h1);
        boundary();
        check(int_ack == 1, "R6 first take", int_ack, 1);
        check(ext_mode == 1 && prev_ext_mode == 0, "R6 mode after first take",
              {ext_mode, prev_ext_mode}, 2);
        check(b_ack == 1 && b_mode == 0, "R6 option off keeps mode", b_mode, 0);
        boundary();
        check(int_ack == 0, "R6 no retake while off", int_ack, 1'b0);
        pulse_std(19'h40000);
        boundary();
        check(int_ack == 1, "R6 retake after re-arm", int_ack, 1);
        check(prev_ext_mode == 1, "R6 prev mode second take", prev_ext_mode, 1);

        // R2 set and clear on the same bit
        clear_all();
        wr(6'o20, 4'd0, 16'h0001);
        pulse_std(PND);
        @(negedge clk);
        std_set = 19'h1; std_clr = 19'h1;
        @(negedge clk);
        std_set = '0; std_clr = '0;
        boundary();
        check(int_ack == 1, "R2 standard set wins", int_ack, 1);
        pulse_std(19'h40000);
        @(negedge clk);
        std_clr = 19'h1;
        @(negedge clk);
        std_clr = '0;
        boundary();
        check(int_ack == 0, "R2 standard clear", int_ack, 0);
        clear_all();
        wr(6'o20, 4'd0, 16'h0000);
        wr(6'o20, 4'd1, 16'h0080);
        pulse_std(PND);
        @(negedge clk);
        ext_set = 16'h0080; ext_clr = 16'h0080;
        @(negedge clk);
        ext_set = '0; ext_clr = '0;
        boundary();
        check(int_ack == 1 && inj_word == 16'o120107, "R2 extended set wins", inj_word, 16'o120107);

        // R8 rejected writes flag bad and change nothing; R7 legal ones do not flag
        clear_all();
        wr(6'o20, 4'd0, 16'h0000);
        wr(6'o20, 4'd1, 16'h0000);
        @(negedge clk);
        wr_valid = 1'b1; wr_dev = 6'o24; wr_fn = 4'd0; wr_data = 16'hFFFF;
        #1 check(wr_bad == 1, "R8 device 24", wr_bad, 1);
        @(negedge clk);
        wr_dev = 6'o20; wr_fn = 4'd2;
        #1 check(wr_bad == 1, "R8 function 2", wr_bad, 1);
        @(negedge clk);
        wr_fn = 4'd3;
        #1 check(wr_bad == 1, "R8 function 3", wr_bad, 1);
        @(negedge clk);
        wr_valid = 1'b0;
        pulse_std(PND | 19'h1);
        @(negedge clk);
        ext_set = 16'h0001;
        @(negedge clk);
        ext_set = '0;
        boundary();
        check(int_ack == 0, "R8 rejected writes left masks", int_ack, 0);
        @(negedge clk);
        wr_valid = 1'b1; wr_dev = 6'o20; wr_fn = 4'd1; wr_data = 16'h0000;
        #1 check(wr_bad == 0 && b_bad == 1, "R8 function 1 by line count",
                 {wr_bad, b_bad}, 1);
        @(negedge clk);
        wr_fn = 4'd0;
        #1 check(wr_bad == 0, "R7 function 0 legal", wr_bad, 0);
        @(negedge clk);
        wr_fn = 4'd5;
        #1 check(wr_bad == 0, "R8 function 5 ignored", wr_bad, 0);
        @(negedge clk);
        wr_valid = 1'b0;

        // R7 mask load takes effect
        wr(6'o20, 4'd1, 16'h0001);
        pulse_std(19'h40000);
        boundary();
        check(int_ack == 1 && inj_word == 16'o120100, "R7 extended mask loaded", inj_word, 16'o120100);

        finish_run();
    end
endmodule